// File: doc/BRIEF.md
# Per-Port Event Counters with Threshold Flags

This block keeps one saturating event counter for every port of a multiport repeater. Each cycle, every port presents one single-cycle strobe per event class (jabber, partition, receive collision, bad link and two further classes). A shared configuration register selects which classes are counted. A port's counter advances by one on any cycle in which at least one enabled class fires on that port.

Three summary flags describe all counters together. The low flag is set while any counter is still small. The high flag is set once any counter has grown large. The full flag is set when any counter has reached its ceiling. Management software reads a counter as two bytes: the lower byte first, then the upper byte. Reading the lower byte captures the upper byte, so the two halves always belong to the same value. An optional clear-on-read setting zeroes a counter when its upper byte is read.

Top module: `evc_event_counters`

## Requirements
- R1: After reset every counter is 0, every event class is disabled, clear-on-read is off, `rd_data` is 0, `flag_low` is 1 and `flag_high` and `flag_full` are 0. Strobes that arrive before the first configuration write leave every counter at 0.
- R2: Strobe bit `p*NUM_EVT+e` is class `e` on port `p`, and bit `e` of `cfg_mask` enables class `e`. Class indices are 0 jabber, 1 partition, 2 receive collision, 3 bad link, 4 elasticity error and 5 short event. A mask written at an edge is applied to strobes from the next edge on. A strobe of an enabled class raises that port's counter by one at the same clock edge.
- R3: A strobe of a disabled class has no effect on any counter.
- R4: When several enabled classes strobe on one port in the same cycle, that counter still rises by exactly one.
- R5: A counter that holds FFFF hex stays at FFFF hex on further events and does not wrap.
- R6: `flag_low` is 1 exactly when at least one counter is below 00FF hex.
- R7: `flag_high` is 1 exactly when at least one counter is above C000 hex.
- R8: `flag_full` is 1 exactly when at least one counter equals FFFF hex.
- R9: A read with `rd_hi`=0 puts bits 7:0 of the selected port's counter on `rd_data` after the edge, using the value held before that edge. The same read captures bits 15:8. `rd_data` keeps its value while `rd_en` is 0.
- R10: A read with `rd_hi`=1 returns the upper byte captured by the most recent lower-byte read, whatever the counter has done since.
- R11: With `cfg_cor`=1, an upper-byte read clears the selected counter at that edge, and an enabled event on that port at the same edge leaves the counter at 1. With `cfg_cor`=0 a read never changes a counter.
- R12: Events on one port never change the counter of another port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_strobe | input | NUM_PORTS*NUM_EVT | Single-cycle event strobes, class-minor per port |
| cfg_we | input | 1 | Write enable for the configuration register |
| cfg_mask | input | NUM_EVT | Per-class count enables to be written |
| cfg_cor | input | 1 | Clear-on-read setting to be written |
| rd_en | input | 1 | Read request |
| rd_hi | input | 1 | 0 selects the lower byte, 1 selects the upper byte |
| rd_port | input | PORT_W | Port whose counter is read |
| rd_data | output | CNT_W/2 | Registered read byte |
| flag_low | output | 1 | Some counter below the low threshold |
| flag_high | output | 1 | Some counter above the high threshold |
| flag_full | output | 1 | Some counter at its maximum |

## Verification
A counter takes an event at the edge that samples its strobe. The three flags are decoded from the counter registers without further delay, so the bench checks them half a cycle after that edge. A read byte is registered and appears on `rd_data` after the edge that samples the request. Clear-on-read and configuration writes take effect at their own edge. The bench drives on the falling edge, advances its reference model exactly one step per rising edge, and compares flags and `rd_data` on every falling edge. The threshold boundaries 00FE/00FF, C000/C001 and the FFFF ceiling are reached with directed runs.

// File: rtl/evc_pkg.sv
package evc_pkg;
    localparam int unsigned DEF_PORTS = 13;
    localparam int unsigned DEF_EVT   = 6;
    localparam int unsigned DEF_CNT_W = 16;

    typedef enum logic {
        BYTE_LO = 1'b0,
        BYTE_HI = 1'b1
    } byte_sel_e;
endpackage

// File: rtl/evc_port_counter.sv
module evc_port_counter #(
    parameter int unsigned NUM_EVT = 6,
    parameter int unsigned CNT_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [NUM_EVT-1:0] mask_i,
    input  logic               clr_i,
    output logic [CNT_W-1:0]   cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    hit;

    always_comb begin
        hit  = |(evt_i & mask_i);
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
        end
        if (hit && (st_d.cnt != CNT_MAX)) begin
            st_d.cnt = st_d.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_MAX && !clr_i) |=> (st_q.cnt == CNT_MAX));

    p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && hit && st_q.cnt != CNT_MAX) |=> ((st_q.cnt - $past(st_q.cnt)) == CNT_W'(1)));

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !hit) |=> $stable(st_q.cnt));

    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !hit) |=> (st_q.cnt == '0));
endmodule

// File: rtl/evc_thresh.sv
module evc_thresh #(
    parameter int unsigned NUM_PORTS = 13,
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned LOW_TH    = 'h00FF,
    parameter int unsigned HIGH_TH   = 'hC000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PORTS*CNT_W-1:0] cnt_flat_i,
    output logic                       low_o,
    output logic                       high_o,
    output logic                       full_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] LOW_V   = CNT_W'(LOW_TH);
    localparam logic [CNT_W-1:0] HIGH_V  = CNT_W'(HIGH_TH);

    logic [CNT_W-1:0] val;

    always_comb begin
        low_o  = 1'b0;
        high_o = 1'b0;
        full_o = 1'b0;
        val    = '0;
        for (int p = 0; p < int'(NUM_PORTS); p++) begin
            val    = cnt_flat_i[p*CNT_W +: CNT_W];
            low_o  = low_o  | (val < LOW_V);
            high_o = high_o | (val > HIGH_V);
            full_o = full_o | (val == CNT_MAX);
        end
    end

    p_full_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> high_o);
endmodule

// File: rtl/evc_rd_port.sv
module evc_rd_port
    import evc_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 13,
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned PORT_W    = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd_en_i,
    input  byte_sel_e                  rd_sel_i,
    input  logic [PORT_W-1:0]          rd_port_i,
    input  logic                       cor_i,
    input  logic [NUM_PORTS*CNT_W-1:0] cnt_flat_i,
    output logic [CNT_W/2-1:0]         rd_data_o,
    output logic [NUM_PORTS-1:0]       clr_o
);
    localparam int unsigned HALF_W = CNT_W / 2;

    typedef struct packed {
        logic [HALF_W-1:0] data;
        logic [HALF_W-1:0] hold;
    } rd_st_t;

    rd_st_t           st_d, st_q;
    logic [CNT_W-1:0] sel;

    always_comb begin
        sel   = '0;
        clr_o = '0;
        for (int p = 0; p < int'(NUM_PORTS); p++) begin
            if (rd_port_i == PORT_W'(p)) begin
                sel      = cnt_flat_i[p*CNT_W +: CNT_W];
                clr_o[p] = rd_en_i && (rd_sel_i == BYTE_HI) && cor_i;
            end
        end
        st_d = st_q;
        if (rd_en_i) begin
            if (rd_sel_i == BYTE_LO) begin
                st_d.data = sel[HALF_W-1:0];
                st_d.hold = sel[CNT_W-1:HALF_W];
            end else begin
                st_d.data = st_q.hold;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = st_q.data;

    p_hold_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en_i && rd_sel_i == BYTE_LO) |=> $stable(st_q.hold));

    p_hi_returns_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && rd_sel_i == BYTE_HI) |=> (rd_data_o == $past(st_q.hold)));

    p_idle_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rd_data_o));

    p_clr_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_o));
endmodule

// File: rtl/evc_event_counters.sv
module evc_event_counters
    import evc_pkg::*;
#(
    parameter int unsigned NUM_PORTS = DEF_PORTS,
    parameter int unsigned NUM_EVT   = DEF_EVT,
    parameter int unsigned CNT_W     = DEF_CNT_W,
    parameter int unsigned LOW_TH    = 'h00FF,
    parameter int unsigned HIGH_TH   = 'hC000,
    localparam int unsigned PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_PORTS*NUM_EVT-1:0] evt_strobe,
    input  logic                         cfg_we,
    input  logic [NUM_EVT-1:0]           cfg_mask,
    input  logic                         cfg_cor,
    input  logic                         rd_en,
    input  logic                         rd_hi,
    input  logic [PORT_W-1:0]            rd_port,
    output logic [CNT_W/2-1:0]           rd_data,
    output logic                         flag_low,
    output logic                         flag_high,
    output logic                         flag_full
);
    typedef struct packed {
        logic [NUM_EVT-1:0] mask;
        logic               cor;
    } cfg_st_t;

    cfg_st_t                    cfg_d, cfg_q;
    logic [NUM_PORTS*CNT_W-1:0] cnt_flat;
    logic [NUM_PORTS-1:0]       clr_vec;
    byte_sel_e                  rd_sel;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d.mask = cfg_mask;
            cfg_d.cor  = cfg_cor;
        end
        rd_sel = rd_hi ? BYTE_HI : BYTE_LO;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    for (genvar p = 0; p < int'(NUM_PORTS); p++) begin : g_port
        evc_port_counter #(
            .NUM_EVT (NUM_EVT),
            .CNT_W   (CNT_W)
        ) i_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt_i  (evt_strobe[p*NUM_EVT +: NUM_EVT]),
            .mask_i (cfg_q.mask),
            .clr_i  (clr_vec[p]),
            .cnt_o  (cnt_flat[p*CNT_W +: CNT_W])
        );
    end

    evc_thresh #(
        .NUM_PORTS (NUM_PORTS),
        .CNT_W     (CNT_W),
        .LOW_TH    (LOW_TH),
        .HIGH_TH   (HIGH_TH)
    ) i_thresh (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_flat_i (cnt_flat),
        .low_o      (flag_low),
        .high_o     (flag_high),
        .full_o     (flag_full)
    );

    evc_rd_port #(
        .NUM_PORTS (NUM_PORTS),
        .CNT_W     (CNT_W),
        .PORT_W    (PORT_W)
    ) i_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en_i    (rd_en),
        .rd_sel_i   (rd_sel),
        .rd_port_i  (rd_port),
        .cor_i      (cfg_q.cor),
        .cnt_flat_i (cnt_flat),
        .rd_data_o  (rd_data),
        .clr_o      (clr_vec)
    );

    p_mask_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_q));
endmodule

// File: tb/test_evc_event_counters.sv
module test_evc_event_counters;
    localparam int NP = 13;
    localparam int NE = 6;
    localparam int CW = 16;
    localparam int PW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP*NE-1:0]  evt_strobe = '0;
    logic              cfg_we = 1'b0;
    logic [NE-1:0]     cfg_mask = '0;
    logic              cfg_cor = 1'b0;
    logic              rd_en = 1'b0;
    logic              rd_hi = 1'b0;
    logic [PW-1:0]     rd_port = '0;
    logic [7:0]        rd_data;
    logic              flag_low, flag_high, flag_full;

    evc_event_counters i_evc_event_counters (
        .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe),
        .cfg_we(cfg_we), .cfg_mask(cfg_mask), .cfg_cor(cfg_cor),
        .rd_en(rd_en), .rd_hi(rd_hi), .rd_port(rd_port), .rd_data(rd_data),
        .flag_low(flag_low), .flag_high(flag_high), .flag_full(flag_full)
    );

    always #2.5 clk = ~clk;

    int          n_tests = 0;
    int          n_fail  = 0;
    logic [15:0] m_cnt [NP];
    logic [NE-1:0] m_mask;
    logic        m_cor;
    logic [7:0]  m_data, m_hold;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic m_low();
        logic r = 1'b0;
        for (int p = 0; p < NP; p++) r |= (m_cnt[p] < 16'h00FF);
        return r;
    endfunction
    function automatic logic m_high();
        logic r = 1'b0;
        for (int p = 0; p < NP; p++) r |= (m_cnt[p] > 16'hC000);
        return r;
    endfunction
    function automatic logic m_full();
        logic r = 1'b0;
        for (int p = 0; p < NP; p++) r |= (m_cnt[p] == 16'hFFFF);
        return r;
    endfunction

    task automatic model_reset();
        for (int p = 0; p < NP; p++) m_cnt[p] = '0;
        m_mask = '0; m_cor = 1'b0; m_data = '0; m_hold = '0;
    endtask

    // one clock: model step at the rising edge, checks at the falling edge
    task automatic tick();
        logic [15:0] nxt [NP];
        logic [7:0]  nd, nh;
        nd = m_data; nh = m_hold;
        for (int p = 0; p < NP; p++) begin
            nxt[p] = m_cnt[p];
            if (rd_en && rd_hi && m_cor && int'(rd_port) == p) nxt[p] = '0;
            if (|(evt_strobe[p*NE +: NE] & m_mask) && nxt[p] != 16'hFFFF) nxt[p] = nxt[p] + 16'd1;
        end
        if (rd_en) begin
            if (!rd_hi) begin
                nd = (int'(rd_port) < NP) ? m_cnt[rd_port][7:0]  : 8'h00;
                nh = (int'(rd_port) < NP) ? m_cnt[rd_port][15:8] : 8'h00;
            end else begin
                nd = m_hold;
            end
        end
        @(posedge clk);
        for (int p = 0; p < NP; p++) m_cnt[p] = nxt[p];
        m_data = nd; m_hold = nh;
        if (cfg_we) begin m_mask = cfg_mask; m_cor = cfg_cor; end
        @(negedge clk);
        chk("R6 flag_low", flag_low, m_low());
        chk("R7 flag_high", flag_high, m_high());
        chk("R8 flag_full", flag_full, m_full());
        chk("R9 rd_data", rd_data, m_data);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        evt_strobe = '0; cfg_we = 0; rd_en = 0;
        repeat (2) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_cfg(input logic [NE-1:0] mask, input logic cor);
        cfg_we = 1'b1; cfg_mask = mask; cfg_cor = cor;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic read16(input int p, output logic [15:0] v);
        logic [7:0] lo;
        rd_en = 1'b1; rd_hi = 1'b0; rd_port = PW'(p);
        tick();
        lo = rd_data;
        rd_hi = 1'b1;
        tick();
        v = {rd_data, lo};
        rd_en = 1'b0; rd_hi = 1'b0;
    endtask

    task automatic strobe(input int p, input logic [NE-1:0] cls, input int n);
        for (int i = 0; i < n; i++) begin
            evt_strobe = '0;
            evt_strobe[p*NE +: NE] = cls;
            tick();
        end
        evt_strobe = '0;
    endtask

    initial begin
        logic [15:0] v;
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 flag_low", flag_low, 1'b1);
        chk("R1 flag_high", flag_high, 1'b0);
        chk("R1 flag_full", flag_full, 1'b0);
        chk("R1 rd_data", rd_data, 8'h00);
        strobe(3, '1, 5);
        read16(3, v);
        chk("R1 masked after reset", v, 16'h0000);

        // R3 / R2: only partition class enabled
        set_cfg(6'b000010, 1'b0);
        strobe(2, 6'b000001, 3);
        read16(2, v);
        chk("R3 disabled class", v, 16'h0000);
        strobe(2, 6'b000010, 4);
        read16(2, v);
        chk("R2 enabled class", v, 16'h0004);

        // R4: all classes at once count once
        set_cfg('1, 1'b0);
        strobe(5, '1, 1);
        read16(5, v);
        chk("R4 simultaneous", v, 16'h0001);
        // R12: neighbours untouched
        read16(4, v);
        chk("R12 port4", v, 16'h0000);
        read16(6, v);
        chk("R12 port6", v, 16'h0000);

        // R6: low flag boundary with all ports
        do_reset();
        set_cfg('1, 1'b0);
        for (int i = 0; i < 254; i++) begin evt_strobe = '1; tick(); end
        evt_strobe = '0;
        chk("R6 all at 00FE", flag_low, 1'b1);
        evt_strobe = '1; tick(); evt_strobe = '0;
        chk("R6 all at 00FF", flag_low, 1'b0);

        // R10: upper byte from the capture, not the live value
        rd_en = 1'b1; rd_hi = 1'b0; rd_port = PW'(7);
        tick();
        chk("R9 lower byte", rd_data, 8'hFF);
        rd_en = 1'b0;
        strobe(7, 6'b000100, 1);
        rd_en = 1'b1; rd_hi = 1'b1;
        tick();
        chk("R10 captured upper", rd_data, 8'h00);
        rd_en = 1'b0; rd_hi = 1'b0;
        read16(7, v);
        chk("R10 fresh pair", v, 16'h0100);
        chk("R11 no clear when off", m_cnt[7], 16'h0100);
        read16(7, v);
        chk("R11 no clear when off", v, 16'h0100);

        // R11: clear on read
        set_cfg('1, 1'b1);
        read16(7, v);
        chk("R11 value before clear", v, 16'h0100);
        read16(7, v);
        chk("R11 cleared", v, 16'h0000);
        strobe(7, 6'b001000, 3);
        rd_en = 1'b1; rd_hi = 1'b0; rd_port = PW'(7);
        tick();
        rd_hi = 1'b1;
        evt_strobe[7*NE +: NE] = 6'b001000;
        tick();
        evt_strobe = '0; rd_en = 1'b0; rd_hi = 1'b0;
        chk("R11 clear upper byte", rd_data, 8'h00);
        set_cfg('1, 1'b0);
        read16(7, v);
        chk("R11 event at clear edge", v, 16'h0001);

        // R7, R8, R5: drive port 0 to its ceiling
        while (m_cnt[0] < 16'hC000) strobe(0, 6'b010000, 1);
        chk("R7 at C000", flag_high, 1'b0);
        strobe(0, 6'b100000, 1);
        chk("R7 at C001", flag_high, 1'b1);
        while (m_cnt[0] < 16'hFFFE) strobe(0, 6'b000001, 1);
        chk("R8 at FFFE", flag_full, 1'b0);
        strobe(0, 6'b000001, 1);
        chk("R8 at FFFF", flag_full, 1'b1);
        strobe(0, '1, 3);
        read16(0, v);
        chk("R5 saturated", v, 16'hFFFF);
        read16(1, v);
        chk("R12 port1", v, 16'h00FF);

        // random phase
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            for (int b = 0; b < NP*NE; b++) evt_strobe[b] = ($urandom % 8) == 0;
            cfg_we   = ($urandom % 50) == 0;
            cfg_mask = NE'($urandom);
            cfg_cor  = ($urandom % 2) == 0;
            rd_en    = ($urandom % 3) == 0;
            rd_hi    = ($urandom % 2) == 0;
            rd_port  = PW'($urandom % 14);
            tick();
        end
        evt_strobe = '0; cfg_we = 0; rd_en = 0;
        set_cfg('1, 1'b0);
        for (int p = 0; p < NP; p++) begin
            read16(p, v);
            chk("R2 random final", v, m_cnt[p]);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule